// File: doc/BRIEF.md
# Byte-Wide Configuration Fetcher with Serial Pass-Through

This block is the master side of a byte-wide configuration load. After a start request it walks an external byte-wide memory from address zero up to a programmed last address. Each byte is read with a slow read strobe made from the configuration clock. A fetch period is eight clocks long: the strobe is low for seven clocks and high for one.

Each byte is latched on the clock edge at which the strobe goes high. The byte is then sent out again, least significant bit first, one bit per clock, on a serial output, so that a downstream device can be chained behind this one. The serial stream starts one and a half clocks after each capture. Because of this, shifting out one byte overlaps with fetching the next, and the stream has no gaps. When the last bit has left, the block raises a done flag, parks the strobe high and holds the serial line idle high.

Top module: `cfg_byte_fetcher`

## Requirements
- R1: While fetching, the read strobe repeats with a period of 8 clocks: low for 7 consecutive clocks, then high for exactly 1 clock.
- R2: A start resets the address to 0. The address increments by exactly one at the clock edge where the strobe falls, and it stays stable for the whole low phase.
- R3: The byte latched is the value present on the data input in the clock before the edge at which the strobe rises. Data presented while the strobe is high is not used.
- R4: Bit b (0 = LSB first) of the byte captured at edge T is driven on ser_out from T + 1.5 + b clocks to T + 2.5 + b clocks. Consecutive bytes follow each other with no gap.
- R5: The bytes fetched are addresses 0 through last_addr inclusive, with last_addr sampled at start. After the final capture, the strobe stays high and the address holds at last_addr.
- R6: done rises on the clock edge 10 clocks after the final capture, once ser_out has returned high. done stays high, with ser_out high, until the next start.
- R7: While no byte is being sent, ser_out is high. Before the first start, the strobe is high and done is low.
- R8: A synchronous reset, applied at any time, returns the block to idle: strobe high, address 0, ser_out high, done low.
- R9: A start is accepted only when the block is idle or done. A start pulse during a fetch has no effect on the strobe, address or serial stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a load (accepted when idle or done) |
| last_addr | input | 18 | Address of the final byte to fetch |
| mem_addr | output | 18 | Byte address to the external memory |
| rd_strobe | output | 1 | Read strobe, 7 clocks low and 1 clock high per byte |
| mem_data | input | 8 | Byte returned by the memory |
| ser_out | output | 1 | Serial pass-through stream, LSB first, idle high |
| done | output | 1 | Load complete |

## Verification
Several properties are checked on every cycle:
- the strobe never stays high for two clocks while fetching;
- the address stays stable through the low phase and steps by one at each strobe fall;
- a new byte is loaded into the shifter only when the previous one is down to its last bit;
- done implies that the strobe and the serial line are both high.

The exact 1.5-clock placement of each serial bit needs scenario checks, because it spans both clock edges. So do the LSB-first order, the stop at the programmed last address, the 10-clock delay to done, and the rejection of a start that arrives during a fetch. The bench samples ser_out on both sides of each falling edge and compares it against a stream rebuilt from its own memory pattern. Its memory model drives corrupted data while the strobe is high, so a capture taken one clock late would be seen.

// File: rtl/cfgf_pkg.sv
package cfgf_pkg;

    localparam int ADDR_W = 18;
    localparam int DATA_W = 8;

    // One byte per strobe period: one serial bit per clock.
    localparam int PERIOD = DATA_W;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,
        ST_DRAIN = 3'd2,
        ST_FLUSH = 3'd3,
        ST_DONE  = 3'd4
    } fetch_state_t;

    function automatic logic can_start(input fetch_state_t s);
        return (s == ST_IDLE) || (s == ST_DONE);
    endfunction

endpackage

// File: rtl/cfgf_strobe_gen.sv
module cfgf_strobe_gen #(
    parameter int PERIOD = cfgf_pkg::PERIOD
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic run,
    input  logic last_byte,
    output logic strobe,
    output logic capture,
    output logic wrap
);
    localparam int PH_W = (PERIOD > 2) ? $clog2(PERIOD) : 1;
    localparam logic [PH_W-1:0] PH_CAP  = PH_W'(PERIOD - 2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(PERIOD - 1);

    logic [PH_W-1:0] ph_q;
    logic            strobe_q;

    assign capture = run && (ph_q == PH_CAP);
    assign wrap    = run && (ph_q == PH_LAST);
    assign strobe  = strobe_q;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            ph_q <= '0;
        end else if (run) begin
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            strobe_q <= 1'b1;
        end else if (restart) begin
            strobe_q <= 1'b0;
        end else if (run) begin
            if (capture)
                strobe_q <= 1'b1;
            else if (wrap && !last_byte)
                strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b1;
        end
    end

    // R1: high phase lasts a single clock while the fetch continues
    assert_high_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
        (run && strobe_q && !last_byte) |=> !strobe_q);

endmodule

// File: rtl/cfgf_addr_ctr.sv
module cfgf_addr_ctr #(
    parameter int ADDR_W = cfgf_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              step,
    input  logic [ADDR_W-1:0] limit_in,
    output logic [ADDR_W-1:0] addr,
    output logic              is_last
);
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            limit_q <= '0;
        end else if (restart) begin
            addr_q  <= '0;
            limit_q <= limit_in;
        end else if (step) begin
            addr_q  <= addr_q + 1'b1;
        end
    end

    assign addr    = addr_q;
    assign is_last = (addr_q == limit_q);

endmodule

// File: rtl/cfgf_serializer.sv
module cfgf_serializer #(
    parameter int DATA_W = cfgf_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic              ser_out,
    output logic              busy
);
    localparam int CNT_W = $clog2(DATA_W + 1);

    logic [DATA_W-1:0] shreg_q;
    logic [CNT_W-1:0]  left_q;
    logic              sbit_q;
    logic              ser_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg_q <= '0;
            left_q  <= '0;
            sbit_q  <= 1'b1;
        end else begin
            if (left_q != '0) begin
                sbit_q  <= shreg_q[0];
                shreg_q <= shreg_q >> 1;
                left_q  <= left_q - 1'b1;
            end else begin
                sbit_q  <= 1'b1;
            end
            if (load) begin
                shreg_q <= din;
                left_q  <= CNT_W'(DATA_W);
            end
        end
    end

    // Opposite-edge stage gives the extra half clock of latency.
    always_ff @(negedge clk) begin
        if (rst)
            ser_q <= 1'b1;
        else
            ser_q <= sbit_q;
    end

    assign ser_out = ser_q;
    assign busy    = (left_q != '0);

    // R4: a byte arrives only when the previous one is on its last bit or gone
    assert_reload_when_drained_R4: assert property (@(posedge clk) disable iff (rst)
        load |-> (left_q <= CNT_W'(1)));

endmodule

// File: rtl/cfg_byte_fetcher.sv
module cfg_byte_fetcher
    import cfgf_pkg::*;
#(
    parameter int AW = cfgf_pkg::ADDR_W,
    parameter int DW = cfgf_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] last_addr,
    output logic [AW-1:0] mem_addr,
    output logic          rd_strobe,
    input  logic [DW-1:0] mem_data,
    output logic          ser_out,
    output logic          done
);
    fetch_state_t state_q;
    logic restart, run, capture, wrap, is_last, busy;

    assign restart = start && can_start(state_q);
    assign run     = (state_q == ST_FETCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else if (restart) begin
            state_q <= ST_FETCH;
        end else begin
            unique case (state_q)
                ST_FETCH: if (wrap && is_last) state_q <= ST_DRAIN;
                ST_DRAIN: if (!busy)           state_q <= ST_FLUSH;
                ST_FLUSH:                      state_q <= ST_DONE;
                default:                       state_q <= state_q;
            endcase
        end
    end

    cfgf_strobe_gen #(.PERIOD(DW)) u_strobe (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .run       (run),
        .last_byte (is_last),
        .strobe    (rd_strobe),
        .capture   (capture),
        .wrap      (wrap)
    );

    cfgf_addr_ctr #(.ADDR_W(AW)) u_addr (
        .clk      (clk),
        .rst      (rst),
        .restart  (restart),
        .step     (wrap && !is_last),
        .limit_in (last_addr),
        .addr     (mem_addr),
        .is_last  (is_last)
    );

    cfgf_serializer #(.DATA_W(DW)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .load    (capture),
        .din     (mem_data),
        .ser_out (ser_out),
        .busy    (busy)
    );

    assign done = (state_q == ST_DONE);

    // R2: address holds through the low phase
    assert_addr_stable_low_R2: assert property (@(posedge clk) disable iff (rst)
        (!rd_strobe && !$past(rd_strobe)) |-> $stable(mem_addr));

    // R2: each strobe fall inside a fetch advances the address by one
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (rst)
        ($fell(rd_strobe) && $past(state_q) == ST_FETCH) |-> (mem_addr == $past(mem_addr) + 1'b1));

    // R5: finished load keeps the strobe parked high
    assert_done_strobe_high_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> rd_strobe);

    // R6: serial line is idle whenever done is shown
    assert_done_line_idle_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ser_out);

endmodule

// File: tb/cfg_byte_fetcher_bench.sv
`timescale 1ns/1ps
module cfg_byte_fetcher_bench;

    localparam int AW = 18;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] last_addr = '0;
    logic [AW-1:0] mem_addr;
    logic          rd_strobe;
    logic [DW-1:0] mem_data;
    logic          ser_out;
    logic          done;

    logic [7:0]    key = 8'h00;
    int            n_checks = 0;
    int            n_fail = 0;
    int            cycles = 0;

    always #2.5 clk = ~clk;

    cfg_byte_fetcher u_cfg_byte_fetcher (
        .clk(clk), .rst(rst), .start(start), .last_addr(last_addr),
        .mem_addr(mem_addr), .rd_strobe(rd_strobe), .mem_data(mem_data),
        .ser_out(ser_out), .done(done)
    );

    function automatic logic [7:0] pat(input logic [AW-1:0] a);
        return (a[7:0] * 8'd29) ^ a[15:8] ^ {6'b0, a[17:16]} ^ key;
    endfunction

    // Memory model: valid data only while the strobe is low (R3)
    assign mem_data = rd_strobe ? ~pat(mem_addr) : pat(mem_addr);

    function automatic logic exp_ser(input int e, input int lst);
        int m;
        m = e - 8;
        if (m >= 0 && m < 8 * (lst + 1)) begin
            logic [7:0] b;
            b = pat(AW'(m / 8));
            return b[m % 8];
        end
        return 1'b1;
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    // Runs one load; j counts posedges since the start-accepting edge.
    task automatic run_job(input int lst, input bit poke_start);
        int total;
        total = 8 * lst + 20;
        @(negedge clk);
        last_addr = AW'(lst);
        start = 1'b1;
        for (int j = 0; j <= total; j++) begin
            @(posedge clk);
            #1;
            if (j == 0) start = 1'b0;
            if (poke_start && j == 13) start = 1'b0;
            chk("R1", "strobe", rd_strobe, (j < 8 * (lst + 1)) ? ((j % 8) == 7) : 1'b1);
            chk(j < 8 * (lst + 1) ? "R2" : "R5", "addr", mem_addr,
                (j < 8 * (lst + 1)) ? (j / 8) : lst);
            chk("R4", "ser_early", ser_out, exp_ser(j - 1, lst));
            chk("R6", "done", done, (j >= 8 * lst + 17));
            #2.5;
            chk("R3", "ser_late", ser_out, exp_ser(j, lst));
            // R9: start during fetch must be ignored
            if (poke_start && j == 12) start = 1'b1;
        end
    endtask

    initial begin
        void'($urandom(32'h1D5E_0C3A));
        repeat (3) @(posedge clk);
        #1;
        chk("R8", "reset strobe", rd_strobe, 1'b1);
        chk("R8", "reset ser", ser_out, 1'b1);
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk("R7", "idle strobe", rd_strobe, 1'b1);
        chk("R7", "idle done", done, 1'b0);
        chk("R7", "idle ser", ser_out, 1'b1);
        chk("R7", "idle addr", mem_addr, 0);

        // Directed: single byte, then a short chain with a stray start (R9)
        key = 8'hA5;
        run_job(0, 1'b0);
        key = 8'h3C;
        run_job(3, 1'b1);

        // Restart from done goes back to address zero
        key = 8'h00;
        run_job(1, 1'b0);

        // Reset in the middle of a fetch (R8)
        @(negedge clk);
        last_addr = AW'(4);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (19) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R8", "mid reset strobe", rd_strobe, 1'b1);
        chk("R8", "mid reset addr", mem_addr, 0);
        chk("R8", "mid reset ser", ser_out, 1'b1);
        chk("R8", "mid reset done", done, 1'b0);

        // Constrained random loads
        for (int k = 0; k < 12; k++) begin
            key = 8'($urandom);
            run_job(int'($urandom_range(0, 6)), 1'($urandom_range(0, 1)));
        end

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule